// File: doc/BRIEF.md
# SPI Status and Interrupt Register Bank

This block holds the event flags of an SPI peripheral and turns them into a single interrupt request. A serializer sends it one-cycle pulses: a received word landed in the receive holding register, a queued word moved into the shift register, or a mode fault occurred. The CPU side sends it pulses when software reads the receive holding register, writes the transmit holding register, or issues the peripheral enable and disable commands. Four level signals from the receive and transmit DMA channels pass straight into the upper half of the status byte.

A small register bus exposes four byte-wide registers: status (0x10), interrupt-enable (0x14), interrupt-disable (0x18) and interrupt-mask (0x1C). The read data is a combinational decode of `reg_addr`. Side effects happen only when `reg_rd` or `reg_wr` is high at a clock edge. The interrupt line is high whenever any status bit is set and its mask bit is set.

Top module: `spi_irq_status`

## Requirements
- R1: After reset, the status byte, the mask byte and `irq` are all zero.
- R2: Status bit 0 (receive-full) is set by `rx_load` and cleared by `rdr_read`. If both arrive in the same cycle, the bit ends up set.
- R3: Status bit 1 (transmit-empty) is 0 while the peripheral is disabled. `en_cmd` enables the peripheral and sets the bit. `dis_cmd` disables it and clears the bit, and wins if both commands arrive in the same cycle. `tx_load` has no effect on the bit while the peripheral is disabled.
- R4: While the peripheral is enabled, `tdr_write` clears bit 1 and `tx_load` sets it. If both arrive in the same cycle, the bit ends up cleared.
- R5: Status bit 3 (overrun) is set by an `rx_load` that arrives while bit 0 is already set and no `rdr_read` arrives in the same cycle.
- R6: Status bit 2 (mode-fault) is set by a `mode_fault` pulse. Bits 2 and 3 stay set until they are cleared by a status read.
- R7: A status read is `reg_rd` with address 0x10. It returns the value the status byte had before the read, and it clears bits 2 and 3. A fault or overrun that arrives in the same cycle as the read leaves its bit set.
- R8: Status bits 4 to 7 follow the current levels of `dma_rx_end`, `dma_tx_end`, `dma_rx_full` and `dma_tx_empty`, in that order.
- R9: A write to 0x14 sets every mask bit whose data bit is 1. A write to 0x18 clears every mask bit whose data bit is 1. Data bits that are 0 leave the mask unchanged. A read of 0x1C returns the mask. Writes to 0x10 and 0x1C are ignored.
- R10: `irq` is high exactly when the bitwise AND of the status byte and the mask byte is non-zero.
- R11: A read of any address other than the four registers returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (enables read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| rx_load | input | 1 | Serializer moved a word into the receive holding register |
| tx_load | input | 1 | Serializer took the queued transmit word |
| mode_fault | input | 1 | Mode fault detected |
| rdr_read | input | 1 | CPU read the receive holding register |
| tdr_write | input | 1 | CPU wrote the transmit holding register |
| en_cmd | input | 1 | Peripheral enable command |
| dis_cmd | input | 1 | Peripheral disable command |
| dma_rx_end | input | 1 | Receive DMA end-of-transfer level |
| dma_tx_end | input | 1 | Transmit DMA end-of-transfer level |
| dma_rx_full | input | 1 | Receive DMA buffer full level |
| dma_tx_empty | input | 1 | Transmit DMA buffer empty level |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the same-cycle collisions, because a design with the wrong priority at one of them still looks correct under isolated pulses.

- **Load and read together.** A design that favours the read would lose a freshly received word.
- **Write and shift together.** A design that favours the shift would report an empty transmit register while a word is still queued.
- **Enable and disable together.** A design that favours enable would raise transmit-empty on a disabled peripheral.
- **Event during a status read.** A fault or overrun that lands on the same edge as a status read would vanish in a design that lets the read win.

The bench also writes zero bits to the enable register and writes directly to the mask address, to catch a mask that is overwritten instead of set and cleared bit by bit. It loads the receive register twice without a read and checks the overrun bit, which catches an overrun that is never set.

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter logic [7:0] ADDR_SR  = 8'h10,
  parameter logic [7:0] ADDR_IER = 8'h14,
  parameter logic [7:0] ADDR_IDR = 8'h18,
  parameter logic [7:0] ADDR_IMR = 8'h1C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rx_load,
  input  logic       tx_load,
  input  logic       mode_fault,
  input  logic       rdr_read,
  input  logic       tdr_write,
  input  logic       en_cmd,
  input  logic       dis_cmd,
  input  logic       dma_rx_end,
  input  logic       dma_tx_end,
  input  logic       dma_rx_full,
  input  logic       dma_tx_empty,
  output logic       irq
);
  logic       enabled, rx_full, tx_empty, modf, ovr;
  logic [7:0] st, mask;
  logic       sr_read;

  assign st      = {dma_tx_empty, dma_rx_full, dma_tx_end, dma_rx_end, ovr, modf, tx_empty, rx_full};
  assign sr_read = reg_rd && (reg_addr == ADDR_SR);
  assign irq     = |(st & mask);

  always_comb begin
    case (reg_addr)
      ADDR_SR:  reg_rdata = st;
      ADDR_IMR: reg_rdata = mask;
      default:  reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled  <= 1'b0;
      rx_full  <= 1'b0;
      tx_empty <= 1'b0;
      modf     <= 1'b0;
      ovr      <= 1'b0;
      mask     <= 8'h00;
    end else begin
      if (dis_cmd)     enabled <= 1'b0;
      else if (en_cmd) enabled <= 1'b1;

      if (rx_load)       rx_full <= 1'b1;
      else if (rdr_read) rx_full <= 1'b0;

      if (dis_cmd)        tx_empty <= 1'b0;
      else if (en_cmd)    tx_empty <= 1'b1;
      else if (!enabled)  tx_empty <= 1'b0;
      else if (tdr_write) tx_empty <= 1'b0;
      else if (tx_load)   tx_empty <= 1'b1;

      if (mode_fault)   modf <= 1'b1;
      else if (sr_read) modf <= 1'b0;

      if (rx_load && rx_full && !rdr_read) ovr <= 1'b1;
      else if (sr_read)                    ovr <= 1'b0;

      if (reg_wr && reg_addr == ADDR_IER)      mask <= mask | reg_wdata;
      else if (reg_wr && reg_addr == ADDR_IDR) mask <= mask & ~reg_wdata;
    end
  end
endmodule

module spi_irq_status_chk #(
  parameter logic [7:0] ADDR_IER = 8'h14
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_load,
  input logic       rdr_read,
  input logic       en_cmd,
  input logic       dis_cmd,
  input logic       mode_fault,
  input logic       sr_read,
  input logic       reg_wr,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] st,
  input logic [7:0] mask,
  input logic       irq
);
  assert_rxf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> st[0]);
  assert_txe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dis_cmd |=> !st[1]);
  assert_txe_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_cmd && !dis_cmd) |=> st[1]);
  assert_ovr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && st[0] && !rdr_read) |=> st[3]);
  assert_modf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st[2] && !sr_read) |=> st[2]);
  assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_IER) |=> ((mask & $past(reg_wdata)) == $past(reg_wdata)));
  assert_no_irq_unmasked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 8'h00) |-> !irq);
endmodule

bind spi_irq_status spi_irq_status_chk #(.ADDR_IER(ADDR_IER)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_load(rx_load), .rdr_read(rdr_read),
  .en_cmd(en_cmd), .dis_cmd(dis_cmd), .mode_fault(mode_fault), .sr_read(sr_read),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .st(st), .mask(mask), .irq(irq)
);

// File: tb/spi_irq_status_tb_top.sv
module spi_irq_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h10;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rx_load = 0, tx_load = 0, mode_fault = 0, rdr_read = 0, tdr_write = 0;
  logic       en_cmd = 0, dis_cmd = 0;
  logic [3:0] dma = 4'h0;
  logic       irq;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  spi_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_load(rx_load), .tx_load(tx_load),
    .mode_fault(mode_fault), .rdr_read(rdr_read), .tdr_write(tdr_write),
    .en_cmd(en_cmd), .dis_cmd(dis_cmd), .dma_rx_end(dma[0]), .dma_tx_end(dma[1]),
    .dma_rx_full(dma[2]), .dma_tx_empty(dma[3]), .irq(irq)
  );

  // {rx_load, rdr_read, tx_load, tdr_write, en, dis, mode_fault, dma[3:0], expected status}
  localparam int NV = 14;
  localparam logic [18:0] VEC [NV] = '{
    {7'b0000100, 4'h0, 8'h02},  // R3 enable sets tx-empty
    {7'b0001000, 4'h0, 8'h00},  // R4 write clears
    {7'b0010000, 4'h0, 8'h02},  // R4 shift sets
    {7'b1000000, 4'h0, 8'h03},  // R2 load sets rx-full
    {7'b1000000, 4'h0, 8'h0B},  // R5 second load -> overrun
    {7'b0100000, 4'h0, 8'h0A},  // R2 read clears rx-full
    {7'b0000001, 4'h5, 8'h5E},  // R6 fault, R8 dma bits 4,6
    {7'b0000010, 4'h0, 8'h0C},  // R3 disable clears tx-empty
    {7'b0010000, 4'h0, 8'h0C},  // R3 shift ignored while disabled
    {7'b0000110, 4'h0, 8'h0C},  // R3 disable wins over enable
    {7'b0000100, 4'hA, 8'hAE},  // R8 dma bits 5,7
    {7'b1100000, 4'h0, 8'h0F},  // R2 load wins over read
    {7'b1100000, 4'h0, 8'h0F},  // R5 load with read: no new overrun needed
    {7'b0011000, 4'h0, 8'h0D}   // R4 write wins over shift
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [7:0] a, input string req, input logic [7:0] exp);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
    rx_load = 0; rdr_read = 0; tx_load = 0; tdr_write = 0; en_cmd = 0; dis_cmd = 0;
    mode_fault = 0; reg_wr = 0; reg_rd = 0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick();
  endtask

  initial begin
    fork
      begin
        #1;
        check("R1 status", reg_rdata, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1;
        peek(8'h10, "R1 status", 8'h00);
        peek(8'h1C, "R1 mask", 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
          {rx_load, rdr_read, tx_load, tdr_write, en_cmd, dis_cmd, mode_fault} = VEC[i][18:12];
          dma = VEC[i][11:8];
          tick();
          peek(8'h10, $sformatf("R2-vec%0d", i), VEC[i][7:0]);
        end

        // R7 status read returns old value then clears bits 2,3
        reg_addr = 8'h10; reg_rd = 1; #1;
        check("R7 read value", reg_rdata, 8'h0D);
        tick();
        peek(8'h10, "R7 cleared", 8'h01);
        // R7 overrun arriving during a status read stays set
        rx_load = 1; reg_addr = 8'h10; reg_rd = 1; tick();
        peek(8'h10, "R7 event wins", 8'h09);
        reg_rd = 1; tick();
        peek(8'h10, "R7 cleared again", 8'h01);

        // R9 / R10 mask handling
        bus_wr(8'h14, 8'h05);
        peek(8'h1C, "R9 enable write", 8'h05);
        check("R10 irq on", {7'b0, irq}, 8'h01);
        bus_wr(8'h14, 8'h00);
        peek(8'h1C, "R9 zero bits no effect", 8'h05);
        bus_wr(8'h18, 8'h01);
        peek(8'h1C, "R9 disable write", 8'h04);
        check("R10 irq off", {7'b0, irq}, 8'h00);
        mode_fault = 1; tick();
        check("R10 irq from fault", {7'b0, irq}, 8'h01);
        bus_wr(8'h1C, 8'hFF);
        peek(8'h1C, "R9 mask write ignored", 8'h04);
        bus_wr(8'h10, 8'h00);
        peek(8'h10, "R9 status write ignored", 8'h05);
        peek(8'h20, "R11 unmapped", 8'h00);
      end
      begin
        repeat (5000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule